// File: doc/BRIEF.md
# Power-Constrained BIST Session Sequencer

This block runs on-chip self-tests for six test engines. The tests are grouped into concurrent sessions so that the summed power of the tests running at one time never goes over a fixed budget. A session table is presented on an input bus. Each entry is a six-bit membership mask, and bit i-1 selects test Ti. A count input says how many entries are valid. When `start` is pulsed, the sequencer walks the entries from index 0 in order.

Each entry is screened before it runs. An entry is rejected if it is empty, if its summed power weight exceeds the limit, or if any two of its members are not a compatible pair. A rejected entry is never run: its error bit is set and the walk moves to the next entry. An accepted entry drives the pattern-generator enable of every member for that test's own length. Each compactor enable follows its generator enable one cycle later. The session lasts until its longest member has finished.

After the last entry, a one-cycle `done` pulse is given. The error vector and the coverage mask hold their values until the next start. The table and count inputs must be held stable while `busy` is high.

Top module: `bss_session_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `tpg_en`, `sig_en`, `sess_err` and `ran_mask` are all zero.
- R2: A `start` pulse while idle clears `sess_err` and `ran_mask` and begins with table entry 0. `busy` is high in the cycle after the pulse. A `start` pulse while `busy` is high has no effect on the schedule, the errors or the coverage.
- R3: An entry whose member weights sum above 4 is skipped and its `sess_err` bit is set. The weights are T1=2, T2=1, T3=1, T4=1, T5=2 and T6=1. Entry k occupies `sess_tbl[6k+5:6k]`, with bit i-1 meaning Ti.
- R4: An entry holding a pair of tests that share none of the groups {T1,T3,T5}, {T1,T3,T4}, {T1,T6}, {T2,T5} or {T2,T6} is skipped, and its `sess_err` bit is set.
- R5: An entry with an all-zero mask is skipped, and its `sess_err` bit is set.
- R6: In an accepted session, `tpg_en` bit i-1 is high for exactly the length of Ti in consecutive cycles, and then low. The lengths are T1=100, T2=10, T3=10, T4=5, T5=10 and T6=100. All members start in the same cycle.
- R7: A session ends only when its longest member ends, and sessions never overlap. The summed weight of the tests whose enables are high never exceeds 4.
- R8: `sig_en` equals the value `tpg_en` had one cycle earlier.
- R9: The table (T3,T4), (T2,T5), (T1,T6) gives exactly 120 cycles in which at least one `tpg_en` bit is high.
- R10: After the last entry, `done` is high for exactly one cycle, with all enables low. `busy` falls in the following cycle.
- R11: `ran_mask` is the OR of the masks of the sessions actually run since the last start.
- R12: A count of 0 gives a `done` pulse with no enables. A count above the table depth is treated as the depth (8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from entry 0 (ignored while busy) |
| sess_tbl | input | 48 | Session table, 8 entries of 6-bit membership masks |
| sess_cnt | input | 4 | Number of valid entries |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last entry |
| tpg_en | output | 6 | Pattern-generator enable per test |
| sig_en | output | 6 | Response-compactor enable per test |
| sess_err | output | 8 | Per-entry rejection flags |
| ran_mask | output | 6 | Tests run at least once since start |

## Verification
Two events can coincide in the last cycle of a session: the expiry of each member's own enable, and the advance of the sequence to the next entry. This happens when a session has members of equal length, as with T2 and T5 in the session (T2,T5), and also at the end of the longest member of any session. Both members must drop in the same cycle. The next session must begin only after that, with no extra cycle taken from or added to any test. The bench counts high cycles and rising edges per test bit, and how many distinct bursts start from an all-zero enable vector. For the three-session table, 120 active cycles with one rise per test shows that neither clipping nor overlap took place.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;
  localparam int NT    = 6;
  localparam int PW_W  = 4;
  localparam int LEN_W = 8;
  localparam int NG    = 5;
  localparam int SUM_W = PW_W + 3;

  // packed lowest slice = T1
  localparam logic [NT*PW_W-1:0]  DEF_WEIGHTS = {4'd1, 4'd2, 4'd1, 4'd1, 4'd1, 4'd2};
  localparam logic [NT*LEN_W-1:0] DEF_LENS    = {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100};
  localparam logic [NG*NT-1:0]    DEF_GROUPS  = {6'b100010, 6'b010010, 6'b100001,
                                                 6'b001101, 6'b010101};

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RUN, ST_FIN} seq_st_e;

  // pairwise compatibility matrix: bit i*NT+j set when Ti and Tj may share a session
  function automatic logic [NT*NT-1:0] pair_table(input logic [NG*NT-1:0] grp);
    logic [NT*NT-1:0] m;
    m = '0;
    for (int i = 0; i < NT; i++) begin
      for (int j = 0; j < NT; j++) begin
        if (i == j) m[i*NT+j] = 1'b1;
        for (int k = 0; k < NG; k++) begin
          if (grp[k*NT+i] && grp[k*NT+j]) m[i*NT+j] = 1'b1;
        end
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/bss_session_check.sv
`timescale 1ns/1ps
module bss_session_check
  import bss_pkg::*;
#(
  parameter logic [NT*PW_W-1:0] WEIGHTS   = DEF_WEIGHTS,
  parameter logic [NT*NT-1:0]   PAIR_OK   = '1,
  parameter int                 PWR_LIMIT = 4
) (
  input  logic [NT-1:0] mask,
  output logic          sess_ok
);
  logic [SUM_W-1:0] pwr_sum;
  logic             pwr_ok;
  logic             pairs_ok;
  logic             non_empty;

  always_comb begin
    pwr_sum = '0;
    for (int i = 0; i < NT; i++) begin
      if (mask[i]) pwr_sum = pwr_sum + SUM_W'(WEIGHTS[i*PW_W +: PW_W]);
    end
  end

  always_comb begin
    pairs_ok = 1'b1;
    for (int i = 0; i < NT; i++) begin
      for (int j = 0; j < NT; j++) begin
        if (mask[i] && mask[j] && !PAIR_OK[i*NT+j]) pairs_ok = 1'b0;
      end
    end
  end

  assign pwr_ok    = (pwr_sum <= SUM_W'(PWR_LIMIT));
  assign non_empty = |mask;
  assign sess_ok   = pwr_ok && pairs_ok && non_empty;
endmodule

// File: rtl/bss_test_timer.sv
`timescale 1ns/1ps
module bss_test_timer #(
  parameter int LEN_W = 8,
  parameter int LEN   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = LEN_W'(LEN);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/bss_session_seq.sv
`timescale 1ns/1ps
module bss_session_seq
  import bss_pkg::*;
#(
  parameter int                  NS        = 8,
  parameter int                  PWR_LIMIT = 4,
  parameter logic [NT*PW_W-1:0]  WEIGHTS   = DEF_WEIGHTS,
  parameter logic [NT*LEN_W-1:0] LENS      = DEF_LENS,
  parameter logic [NG*NT-1:0]    GROUPS    = DEF_GROUPS,
  parameter int                  IDX_W     = (NS > 1) ? $clog2(NS) : 1,
  parameter int                  CNT_W     = $clog2(NS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NS*NT-1:0]     sess_tbl,
  input  logic [CNT_W-1:0]     sess_cnt,
  output logic                 busy,
  output logic                 done,
  output logic [NT-1:0]        tpg_en,
  output logic [NT-1:0]        sig_en,
  output logic [NS-1:0]        sess_err,
  output logic [NT-1:0]        ran_mask
);
  localparam logic [NT*NT-1:0] PAIR_OK = pair_table(GROUPS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  seq_st_e          state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NS-1:0]    err_q, err_d;
  logic [NT-1:0]    ran_q, ran_d;
  logic [NT-1:0]    sig_q;
  logic [NT-1:0]    act;
  logic [NT-1:0]    cur_mask;
  logic [CNT_W-1:0] eff_cnt;
  logic             is_last;
  logic             sess_ok;
  logic             load_go;
  logic             ctl_en;

  assign eff_cnt  = (sess_cnt > CNT_W'(NS)) ? CNT_W'(NS) : sess_cnt;
  assign cur_mask = sess_tbl[idx_q*NT +: NT];
  assign is_last  = (CNT_W'(idx_q) + CNT_W'(1)) >= eff_cnt;

  bss_session_check #(
    .WEIGHTS  (WEIGHTS),
    .PAIR_OK  (PAIR_OK),
    .PWR_LIMIT(PWR_LIMIT)
  ) u_check (
    .mask   (cur_mask),
    .sess_ok(sess_ok)
  );

  for (genvar g = 0; g < NT; g++) begin : g_timer
    bss_test_timer #(
      .LEN_W(LEN_W),
      .LEN  (int'(LENS[g*LEN_W +: LEN_W]))
    ) u_timer (
      .clk   (clk),
      .rst_n (rst_s_n),
      .load  (load_go && cur_mask[g]),
      .active(act[g])
    );
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    err_d   = err_q;
    ran_d   = ran_q;
    load_go = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          idx_d   = '0;
          err_d   = '0;
          ran_d   = '0;
          state_d = (eff_cnt == '0) ? ST_FIN : ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (sess_ok) begin
          load_go = 1'b1;
          ran_d   = ran_q | cur_mask;
          state_d = ST_RUN;
        end else begin
          err_d[idx_q] = 1'b1;
          if (is_last) begin
            state_d = ST_FIN;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_CHECK;
          end
        end
      end
      ST_RUN: begin
        if (act == '0) begin
          if (is_last) begin
            state_d = ST_FIN;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_CHECK;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_q != ST_IDLE) || start;

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= '0;
      ran_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      ran_q   <= ran_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sig_q <= '0;
    else          sig_q <= act;
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign tpg_en   = act;
  assign sig_en   = sig_q;
  assign sess_err = err_q;
  assign ran_mask = ran_q;
endmodule

// File: rtl/bss_session_seq_chk.sv
`timescale 1ns/1ps
module bss_session_seq_chk
  import bss_pkg::*;
#(
  parameter int                 PWR_LIMIT = 4,
  parameter logic [NT*PW_W-1:0] WEIGHTS   = DEF_WEIGHTS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [NT-1:0] tpg_en,
  input logic [NT-1:0] sig_en,
  input logic [NT-1:0] ran_mask
);
  logic [SUM_W-1:0] act_pwr;
  always_comb begin
    act_pwr = '0;
    for (int i = 0; i < NT; i++) begin
      if (tpg_en[i]) act_pwr = act_pwr + SUM_W'(WEIGHTS[i*PW_W +: PW_W]);
    end
  end

  a_r7_power_cap: assert property (@(posedge clk) disable iff (!rst_n)
    act_pwr <= SUM_W'(PWR_LIMIT));

  a_r7_no_join_midsession: assert property (@(posedge clk) disable iff (!rst_n)
    ((tpg_en & ~$past(tpg_en)) != '0) |-> ($past(tpg_en) == '0));

  a_r6_enables_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tpg_en != '0) |-> busy);

  a_r8_sig_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sig_en == $past(tpg_en)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tpg_en == '0 && sig_en == '0));

  a_r10_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r11_cover_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (($past(ran_mask) & ~ran_mask) == '0));
endmodule

bind bss_session_seq bss_session_seq_chk #(
  .PWR_LIMIT(PWR_LIMIT),
  .WEIGHTS  (WEIGHTS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .tpg_en  (tpg_en),
  .sig_en  (sig_en),
  .ran_mask(ran_mask)
);

// File: tb/test_bss_session_seq.sv
`timescale 1ns/1ps
module test_bss_session_seq;
  import bss_pkg::*;
  localparam int NSB = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [NSB*NT-1:0] tbl;
  logic [3:0]       cnt;
  logic             busy, done;
  logic [NT-1:0]    tpg_en, sig_en, ran_mask;
  logic [NSB-1:0]   sess_err;

  always #10 clk = ~clk;

  bss_session_seq i_bss_session_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sess_tbl(tbl), .sess_cnt(cnt),
    .busy(busy), .done(done), .tpg_en(tpg_en), .sig_en(sig_en),
    .sess_err(sess_err), .ran_mask(ran_mask)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int wt[NT]  = '{2, 1, 1, 1, 2, 1};
  int len[NT] = '{100, 10, 10, 5, 10, 100};

  int w_total, w_sess, w_sigbad, w_over, w_done, w_dirty, w_gap;
  int w_cnt[NT];
  int w_rise[NT];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary_and_end();
  end

  // pulse start, then sample every cycle until busy falls
  task automatic launch_and_watch(input int restart_at);
    logic [NT-1:0] prev;
    int cyc, done_at, low_at, p;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    w_total = 0; w_sess = 0; w_sigbad = 0; w_over = 0; w_done = 0; w_dirty = 0;
    for (int i = 0; i < NT; i++) begin w_cnt[i] = 0; w_rise[i] = 0; end
    prev = '0; cyc = 0; done_at = -1; low_at = -1;
    while (cyc < 3000) begin
      if (!busy) begin low_at = cyc; break; end
      if (tpg_en != '0) w_total++;
      if (prev == '0 && tpg_en != '0) w_sess++;
      if (sig_en !== prev) w_sigbad++;
      p = 0;
      for (int i = 0; i < NT; i++) begin
        if (tpg_en[i]) begin w_cnt[i]++; p += wt[i]; end
        if (tpg_en[i] && !prev[i]) w_rise[i]++;
      end
      if (p > 4) w_over++;
      if (done) begin
        w_done++; done_at = cyc;
        if (tpg_en != '0 || sig_en != '0) w_dirty++;
      end
      prev = tpg_en;
      if (cyc == restart_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    w_gap = (low_at >= 0 && done_at >= 0) ? (low_at - done_at) : -1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; tbl = '0; cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 enables in reset", int'({tpg_en, sig_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 err/cover after reset", int'({sess_err, ran_mask}), 0);
  endtask

  task automatic t_schedule();
    tbl = '0; cnt = 4'd3;
    tbl[0 +: 6] = 6'b001100; tbl[6 +: 6] = 6'b010010; tbl[12 +: 6] = 6'b100001;
    launch_and_watch(-1);
    chk("R9 total active cycles", w_total, 120);
    for (int i = 0; i < NT; i++) begin
      chk($sformatf("R6 T%0d enable length", i + 1), w_cnt[i], len[i]);
      chk($sformatf("R6 T%0d single burst", i + 1), w_rise[i], 1);
    end
    chk("R7 session count", w_sess, 3);
    chk("R7 power cap", w_over, 0);
    chk("R8 compactor lag", w_sigbad, 0);
    chk("R10 done pulses", w_done, 1);
    chk("R10 quiet at done", w_dirty, 0);
    chk("R10 busy falls next", w_gap, 1);
    chk("R3 no errors", int'(sess_err), 0);
    chk("R11 coverage all", int'(ran_mask), 6'h3F);
  endtask

  task automatic t_power_fail();
    tbl = '0; cnt = 4'd2;
    tbl[0 +: 6] = 6'b010101; tbl[6 +: 6] = 6'b001101;
    launch_and_watch(-1);
    chk("R3 overweight entry flagged", int'(sess_err), 1);
    chk("R3 only second runs", w_total, 100);
    chk("R11 coverage partial", int'(ran_mask), 6'b001101);
    chk("R6 T4 length in trio", w_cnt[3], 5);
  endtask

  task automatic t_compat_fail();
    tbl = '0; cnt = 4'd3;
    tbl[0 +: 6] = 6'b000011; tbl[6 +: 6] = 6'b001000; tbl[12 +: 6] = 6'b000000;
    launch_and_watch(-1);
    chk("R4 R5 error flags", int'(sess_err), 5);
    chk("R4 incompatible not run", w_cnt[0] + w_cnt[1], 0);
    chk("R5 empty gives only T4 time", w_total, 5);
    chk("R11 coverage T4", int'(ran_mask), 6'b001000);
    chk("R10 done after skip", w_done, 1);
  endtask

  task automatic t_start_busy();
    tbl = '0; cnt = 4'd3;
    tbl[0 +: 6] = 6'b001100; tbl[6 +: 6] = 6'b010010; tbl[12 +: 6] = 6'b100001;
    launch_and_watch(30);
    chk("R2 restart ignored total", w_total, 120);
    chk("R2 restart ignored sessions", w_sess, 3);
    chk("R2 restart ignored coverage", int'(ran_mask), 6'h3F);
    chk("R2 restart ignored done", w_done, 1);
  endtask

  task automatic t_counts();
    tbl = '0; cnt = 4'd0;
    launch_and_watch(-1);
    chk("R12 zero count no enables", w_total, 0);
    chk("R12 zero count done", w_done, 1);
    chk("R12 zero count no error", int'(sess_err), 0);
    for (int k = 0; k < NSB; k++) tbl[k*6 +: 6] = 6'b001000;
    cnt = 4'd15;
    launch_and_watch(-1);
    chk("R12 clamp T4 bursts", w_rise[3], 8);
    chk("R12 clamp T4 cycles", w_cnt[3], 40);
    chk("R12 clamp no error", int'(sess_err), 0);
  endtask

  initial begin
    t_reset();
    t_schedule();
    t_power_fail();
    t_compat_fail();
    t_start_busy();
    t_counts();
    summary_and_end();
  end
endmodule